// File: doc/BRIEF.md
# Dynamic Bus Sizing Line-Fill Sequencer

This block sits between a processor core with a 32-bit data bus and a memory system whose ports may be 32, 16 or 8 bits wide. The core hands it one read request: a word address, four active-low byte enables and a flag that marks the request as a 16-byte cache line fill. The block then runs as many bus cycles as the port width needs. For each cycle it shows the remaining byte enables, the word address and the narrow-port address bits (byte-select A0, which doubles as the low-byte enable, half-word select A1, and the active-low high-byte enable BHE_n).

The memory ends each cycle with a ready strobe. On that same edge it reports its width on two active-low size inputs, `mem_bs8_n` and `mem_bs16_n`. The block moves the bytes that arrived on the low lanes into their proper 32-bit lanes, clears them from the remaining set and either goes on with the same word, goes to the next word of the line, or completes with a one-cycle `done` pulse and the assembled data.

A line fill always fetches all four words of the line, whatever byte enables come with it. It starts at the line-aligned address and steps upward. The port width may change from one cycle to the next, including in the middle of a fill.

Top module: `bsz_line_fill_seq`

## Requirements
- R1: After reset `req_ready` is 1, `mem_strobe` is 0 and `done` is 0; while a request is in progress `req_ready` is 0.
- R2: Whenever `mem_strobe` is 1, let k be the lowest lane whose `mem_be_n` bit is 0. The outputs are then: `mem_a0` = bit 0 of k; `mem_a1` = 1 exactly when `mem_be_n[1:0]` is 2'b11; `mem_bhe_n` = `mem_be_n[3]` when `mem_a1` is 1, and `mem_be_n[1]` otherwise.
- R3: On the first cycle of a line fill `mem_be_n` is 4'b0000 and `mem_a0`, `mem_a1` and `mem_bhe_n` are all 0, whatever `req_be_n` was.
- R4: A ready cycle with `mem_bs8_n`=0 transfers exactly one byte, the lowest remaining lane, taken from `mem_rdata[7:0]`. This holds even when `mem_bs16_n` is also 0.
- R5: A ready cycle with `mem_bs8_n`=1 and `mem_bs16_n`=0 transfers the remaining bytes of the half-word chosen by `mem_a1`, taken from `mem_rdata[15:0]`.
- R6: A ready cycle with both size inputs at 1 transfers every remaining byte of the word from its own lane. A line fill then moves on to the next word with all enables active.
- R7: A line fill reads the four words from the line-aligned word address upward. Against an 8-bit port it takes sixteen ready cycles.
- R8: The port width is sampled afresh on every ready cycle, so a width change in the middle of a fill is honoured for the remaining bytes.
- R9: `done` pulses for one cycle, on the cycle after the final ready. `rd_line` word i then holds line word i (a single request uses word 0), and lanes whose enable was inactive read as 0.
- R10: While `mem_strobe` is 1 and `mem_ready` is 0, the address and enables hold steady. `mem_ready` has no effect while `mem_strobe` is 0.
- R11: A single request with `req_be_n`=4'b1111 completes with `done` and no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Block idle and accepting a request |
| req_addr | input | ADDR_W-2 | Word address of the request |
| req_be_n | input | 4 | Active-low byte enables of the request |
| req_fill | input | 1 | Request is a full line fill |
| done | output | 1 | One-cycle completion pulse |
| rd_line | output | LINE_WORDS*DATA_W | Assembled read data, word 0 in the low bits |
| mem_strobe | output | 1 | Bus cycle in progress |
| mem_addr | output | ADDR_W-2 | Word address of the current cycle |
| mem_be_n | output | 4 | Remaining active-low byte enables |
| mem_a0 | output | 1 | Byte select, also low-byte enable |
| mem_a1 | output | 1 | Half-word select |
| mem_bhe_n | output | 1 | Active-low high-byte enable |
| mem_bs8_n | input | 1 | Active-low 8-bit port indication |
| mem_bs16_n | input | 1 | Active-low 16-bit port indication |
| mem_ready | input | 1 | Memory ends the current cycle |
| mem_rdata | input | DATA_W | Read data from memory |

## Verification
On every cycle the assertions check four things:
- a fill begins with all enables active and both address bits and the high-byte enable low;
- an 8-bit ready cycle removes exactly one byte;
- a 32-bit ready cycle either finishes or restarts the next word;
- the outputs hold through wait states, and `done` is a lone pulse.

Only the bench scenarios can show the data side. That covers whether bytes arriving on the low lanes land in the right 32-bit lanes and whether the number of cycles per width and per mix of enables is right. It also covers the fill's word order, a width change mid-fill, an empty request and a stray ready while idle.

// File: rtl/bsz_pkg.sv
package bsz_pkg;

   typedef enum logic [1:0] {
      PW_32 = 2'd0,
      PW_16 = 2'd1,
      PW_8  = 2'd2
   } port_w_e;

   // 8-bit indication wins over 16-bit
   function automatic port_w_e size_decode(input logic bs8_n, input logic bs16_n);
      if (!bs8_n)       return PW_8;
      else if (!bs16_n) return PW_16;
      else              return PW_32;
   endfunction

endpackage

// File: rtl/bsz_addr_gen.sv
module bsz_addr_gen #(
   parameter int NUM_LANES = 4
) (
   input  logic [NUM_LANES-1:0] act,
   output logic [1:0]           low_idx,
   output logic                 a0,
   output logic                 a1,
   output logic                 bhe_n
);
   generate
      if (NUM_LANES != 4) begin : g_bad_lanes
         $error("bsz_addr_gen: NUM_LANES must be 4");
      end
   endgenerate

   always_comb begin
      low_idx = '0;
      for (int i = NUM_LANES - 1; i >= 0; i--) begin
         if (act[i]) low_idx = 2'(i);
      end
      a0    = low_idx[0];
      a1    = ~(act[0] | act[1]);
      bhe_n = a1 ? ~act[3] : ~act[1];
   end

endmodule

// File: rtl/bsz_lane_steer.sv
module bsz_lane_steer
   import bsz_pkg::*;
#(
   parameter int NUM_LANES = 4
) (
   input  logic [NUM_LANES-1:0]   act,
   input  port_w_e                pw,
   input  logic [1:0]             low_idx,
   input  logic                   a1,
   input  logic [8*NUM_LANES-1:0] d_in,
   output logic [NUM_LANES-1:0]   take,
   output logic [8*NUM_LANES-1:0] d_out
);
   generate
      if (NUM_LANES != 4) begin : g_bad_lanes
         $error("bsz_lane_steer: NUM_LANES must be 4");
      end
      for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
         localparam int HALF_OFS = 8 * (g % 2);
         localparam logic UPPER  = (g >= 2);
         always_comb begin
            unique case (pw)
               PW_8: begin
                  take[g]           = act[g] && (low_idx == 2'(g));
                  d_out[8*g +: 8]   = d_in[7:0];
               end
               PW_16: begin
                  take[g]           = act[g] && (a1 == UPPER);
                  d_out[8*g +: 8]   = d_in[HALF_OFS +: 8];
               end
               default: begin
                  take[g]           = act[g];
                  d_out[8*g +: 8]   = d_in[8*g +: 8];
               end
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/bsz_line_fill_seq.sv
module bsz_line_fill_seq
   import bsz_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINE_WORDS = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   output logic                         req_ready,
   input  logic [ADDR_W-1:2]            req_addr,
   input  logic [3:0]                   req_be_n,
   input  logic                         req_fill,
   output logic                         done,
   output logic [LINE_WORDS*DATA_W-1:0] rd_line,
   output logic                         mem_strobe,
   output logic [ADDR_W-1:2]            mem_addr,
   output logic [3:0]                   mem_be_n,
   output logic                         mem_a0,
   output logic                         mem_a1,
   output logic                         mem_bhe_n,
   input  logic                         mem_bs8_n,
   input  logic                         mem_bs16_n,
   input  logic                         mem_ready,
   input  logic [DATA_W-1:0]            mem_rdata
);
   localparam int LANES = DATA_W / 8;
   localparam int IDX_W = $clog2(LINE_WORDS);
   localparam int LAST  = LINE_WORDS - 1;

   generate
      if (DATA_W != 32) begin : g_bad_data
         $error("bsz_line_fill_seq: DATA_W must be 32");
      end
      if (LINE_WORDS < 2 || (1 << IDX_W) != LINE_WORDS) begin : g_bad_line
         $error("bsz_line_fill_seq: LINE_WORDS must be a power of two >= 2");
      end
      if (ADDR_W < IDX_W + 3) begin : g_bad_addr
         $error("bsz_line_fill_seq: ADDR_W too small");
      end
   endgenerate

   logic                         busy_q, fill_q, done_q;
   logic [IDX_W-1:0]             idx_q;
   logic [LANES-1:0]             rem_q, rem_nxt, take, take_g;
   logic [ADDR_W-1:2]            base_q;
   logic [LINE_WORDS*DATA_W-1:0] line_q;
   logic [DATA_W-1:0]            steered;
   logic [1:0]                   low_idx;
   logic                         beat, word_end, last_word;
   port_w_e                      pw;

   assign req_ready  = ~busy_q;
   assign done       = done_q;
   assign rd_line    = line_q;
   assign mem_strobe = busy_q & (|rem_q);
   assign mem_be_n   = ~rem_q;
   assign mem_addr   = fill_q ? {base_q[ADDR_W-1:2+IDX_W], idx_q} : base_q;
   assign pw         = size_decode(mem_bs8_n, mem_bs16_n);
   assign beat       = mem_strobe & mem_ready;
   assign take_g     = beat ? take : '0;
   assign rem_nxt    = rem_q & ~take_g;
   assign word_end   = busy_q & (rem_nxt == '0);
   assign last_word  = ~fill_q | (idx_q == IDX_W'(LAST));

   bsz_addr_gen #(.NUM_LANES(LANES)) u_addr (
      .act(rem_q), .low_idx(low_idx), .a0(mem_a0), .a1(mem_a1), .bhe_n(mem_bhe_n)
   );

   bsz_lane_steer #(.NUM_LANES(LANES)) u_steer (
      .act(rem_q), .pw(pw), .low_idx(low_idx), .a1(mem_a1),
      .d_in(mem_rdata), .take(take), .d_out(steered)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         fill_q <= 1'b0;
         done_q <= 1'b0;
         idx_q  <= '0;
         rem_q  <= '0;
         base_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (req_valid) begin
               busy_q <= 1'b1;
               fill_q <= req_fill;
               rem_q  <= req_fill ? '1 : ~req_be_n;
               base_q <= req_addr;
               idx_q  <= '0;
            end
         end else begin
            rem_q <= rem_nxt;
            if (word_end) begin
               if (last_word) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  idx_q <= idx_q + 1'b1;
                  rem_q <= '1;
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= '0;
      end else if (!busy_q && req_valid) begin
         line_q <= '0;
      end else begin
         for (int w = 0; w < LINE_WORDS; w++) begin
            for (int l = 0; l < LANES; l++) begin
               if (take_g[l] && idx_q == IDX_W'(w))
                  line_q[w*DATA_W + 8*l +: 8] <= steered[8*l +: 8];
            end
         end
      end
   end

   // R3: fill begins with every enable active and the narrow address low
   a_r3_fill_first: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_fill) |=>
         (mem_be_n == 4'b0000 && !mem_a0 && !mem_a1 && !mem_bhe_n));

   // R4: an 8-bit cycle removes exactly one byte
   a_r4_one_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && !mem_bs8_n && $countones(rem_q) > 1) |=>
         ($countones(rem_q) == $past($countones(rem_q)) - 1));

   // R6: a full-width cycle finishes the word
   a_r6_full_word: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && mem_bs8_n && mem_bs16_n) |=> (done || mem_be_n == 4'b0000));

   // R10: wait states hold the cycle steady
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_strobe && !mem_ready) |=>
         (mem_strobe && $stable(mem_addr) && $stable(mem_be_n)));

   // R9: done is a single pulse and leaves the block idle
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (req_ready && !mem_strobe));

endmodule

// File: tb/bsz_line_fill_seq_tb.sv
module bsz_line_fill_seq_tb;
   localparam int ADDR_W = 32;
   localparam int DATA_W = 32;
   localparam int LW     = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [ADDR_W-1:2] req_addr = '0;
   logic [3:0]        req_be_n = 4'hF;
   logic              req_fill = 1'b0;
   logic              done;
   logic [LW*DATA_W-1:0] rd_line;
   logic              mem_strobe;
   logic [ADDR_W-1:2] mem_addr;
   logic [3:0]        mem_be_n;
   logic              mem_a0, mem_a1, mem_bhe_n;
   logic              mem_bs8_n = 1'b1, mem_bs16_n = 1'b1, mem_ready = 1'b0;
   logic [DATA_W-1:0] mem_rdata = '0;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   // responder controls: 0=32-bit, 1=16-bit, 2=8-bit, 3=both size inputs low
   int pol1 = 0, pol2 = 0, switch_at = 1000, wait_n = 0, wcnt = 0, beats = 0;
   bit stray = 1'b0, first_seen = 1'b0;
   logic [3:0] f_be_n;
   logic f_a0, f_a1, f_bhe_n;
   logic [ADDR_W-1:2] first_addr, last_addr;

   bsz_line_fill_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LW)) u_dut (.*);

   always #10 clk = ~clk;

   function automatic logic [31:0] mem_word(input logic [ADDR_W-1:2] a);
      logic [7:0] b;
      b = a[9:2];
      return {b ^ 8'h3C, b + 8'h11, ~b, b ^ 8'hC5};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // memory model: decides width, wait states and data per bus cycle
   always @(negedge clk) begin
      if (mem_strobe) begin
         int pol, k;
         logic [31:0] w;
         logic ea0, ea1, ebhe;
         k = 0;
         for (int i = 3; i >= 0; i--) if (!mem_be_n[i]) k = i;
         ea0  = k[0];
         ea1  = (mem_be_n[1:0] == 2'b11);
         ebhe = ea1 ? mem_be_n[3] : mem_be_n[1];
         chk({mem_a0, mem_a1, mem_bhe_n} == {ea0, ea1, ebhe}, "R2 decode",
             {mem_a0, mem_a1, mem_bhe_n}, {ea0, ea1, ebhe});
         if (!first_seen) begin
            first_seen = 1'b1;
            f_be_n = mem_be_n; f_a0 = mem_a0; f_a1 = mem_a1; f_bhe_n = mem_bhe_n;
            first_addr = mem_addr;
         end
         if (wcnt < wait_n) begin
            wcnt++;
            mem_ready = 1'b0;
         end else begin
            wcnt = 0;
            pol = (beats >= switch_at) ? pol2 : pol1;
            beats++;
            last_addr = mem_addr;
            w = mem_word(mem_addr);
            mem_ready = 1'b1;
            mem_bs8_n  = !(pol == 2 || pol == 3);
            mem_bs16_n = !(pol == 1 || pol == 3);
            if (pol >= 2)      mem_rdata = {24'h5A5A5A, w[8*{mem_a1, mem_a0} +: 8]};
            else if (pol == 1) mem_rdata = {16'hC3C3, w[16*mem_a1 +: 16]};
            else               mem_rdata = w;
         end
      end else begin
         mem_ready  = stray;
         mem_bs8_n  = 1'b1;
         mem_bs16_n = 1'b1;
         mem_rdata  = 32'hFFFF_FFFF;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic run_req(input logic [ADDR_W-1:2] a, input logic [3:0] be_n, input bit fill,
                          input int p1, input int p2, input int sw, input int ws);
      pol1 = p1; pol2 = p2; switch_at = sw; wait_n = ws;
      beats = 0; wcnt = 0; first_seen = 1'b0;
      @(negedge clk);
      req_addr = a; req_be_n = be_n; req_fill = fill; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R1 busy", req_ready, 0);
      for (int t = 0; t < 300 && !done; t++) @(negedge clk);
      chk(done == 1'b1, "R9 done seen", done, 1);
      @(negedge clk);
      chk(done == 1'b0, "R9 done one cycle", done, 0);
   endtask

   function automatic logic [31:0] masked(input logic [31:0] w, input logic [3:0] be_n);
      logic [31:0] r;
      for (int l = 0; l < 4; l++) r[8*l +: 8] = be_n[l] ? 8'h00 : w[8*l +: 8];
      return r;
   endfunction

   task automatic t_reset;
      chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
      chk(mem_strobe == 1'b0, "R1 reset strobe", mem_strobe, 0);
      chk(done == 1'b0, "R1 reset done", done, 0);
   endtask

   task automatic t_single(input logic [ADDR_W-1:2] a, input logic [3:0] be_n, input int p,
                           input int ws, input int exp_beats, input string tag);
      run_req(a, be_n, 1'b0, p, p, 1000, ws);
      chk(beats == exp_beats, {tag, " cycle count"}, beats, exp_beats);
      chk(rd_line[31:0] == masked(mem_word(a), be_n), {tag, " data"},
          rd_line[31:0], masked(mem_word(a), be_n));
   endtask

   task automatic t_fill(input logic [ADDR_W-1:2] a, input logic [3:0] be_n, input int p1,
                         input int p2, input int sw, input int ws, input int exp_beats, input string tag);
      logic [ADDR_W-1:2] b;
      b = {a[ADDR_W-1:4], 2'b00};
      run_req(a, be_n, 1'b1, p1, p2, sw, ws);
      chk(f_be_n == 4'b0000 && !f_a0 && !f_a1 && !f_bhe_n, "R3 first fill cycle",
          {f_be_n, f_a0, f_a1, f_bhe_n}, 0);
      chk(first_addr == b, "R7 first word", first_addr, b);
      chk(last_addr == b + 3, "R7 last word", last_addr, b + 3);
      chk(beats == exp_beats, {tag, " cycle count"}, beats, exp_beats);
      for (int w = 0; w < LW; w++)
         chk(rd_line[32*w +: 32] == mem_word(b + w), {tag, " line data"},
             rd_line[32*w +: 32], mem_word(b + w));
   endtask

   task automatic t_empty;
      run_req(30'h55, 4'b1111, 1'b0, 0, 0, 1000, 0);
      chk(beats == 0, "R11 no bus cycle", beats, 0);
      chk(rd_line[31:0] == 32'h0, "R11 data zero", rd_line[31:0], 0);
   endtask

   task automatic t_stray;
      stray = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk(!done && req_ready && !mem_strobe, "R10 stray ready ignored",
             {done, req_ready, mem_strobe}, 3'b010);
      end
      stray = 1'b0;
   endtask

   initial begin
      #5;
      t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_stray();
      t_single(30'h100, 4'b0000, 0, 0, 1, "R6 32-bit word");
      t_single(30'h101, 4'b0000, 1, 1, 2, "R5 16-bit word with waits R10");
      t_single(30'h102, 4'b0100, 3, 0, 3, "R4 8-bit priority");
      t_single(30'h103, 4'b1011, 1, 0, 1, "R5 R9 single upper byte");
      t_single(30'h104, 4'b0110, 2, 2, 2, "R4 8-bit split enables");
      t_fill(30'h20B, 4'b1010, 2, 2, 1000, 0, 16, "R7 8-bit fill");
      t_fill(30'h211, 4'b1111, 2, 1, 2, 0, 9, "R8 width change mid-fill");
      t_fill(30'h30E, 4'b0000, 0, 0, 1000, 2, 4, "R6 32-bit fill");
      t_empty();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule